// File: doc/BRIEF.md
# Serial Flash Interrupt Status Controller

This block gathers completion events from a serial flash controller and turns them into a single level interrupt. Each source has a sticky raw status bit, which a one-cycle event pulse sets, and an enable bit. Software reads the sources through a small register port and changes them through that port. The enable mask has no plain write. Software turns enables on through one register and off through another, and each of these writes changes only the bits written as one.

Two sources are handled. The word-complete event sits at bit 1 and the frame-complete event at bit 0. A masked view, the raw status ANDed with the enable mask, drives the interrupt. Software acknowledges an event by writing ones to that view. Software can also write ones to the raw register to raise status bits, so the interrupt path can be tested without the flash engine. A read of zero from the masked view means nothing is pending.

Top module: `flash_irq_ctrl`

## Requirements
- R1: After reset, every raw status bit and every enable bit is zero, `irq_o` is low, and a read at any offset returns zero.
- R2: A one on `evt_i[b]` at a rising clock edge sets raw bit b. Bit 1 is word-complete and bit 0 is frame-complete. The bit then reads as one at offset 0x20 and stays set until cleared.
- R3: A write to offset 0x28 sets each enable bit whose write-data bit is one. Enable bits written as zero keep their value.
- R4: A write to offset 0x2C clears each enable bit whose write-data bit is one. Enable bits written as zero keep their value. A read at 0x28 or at 0x2C returns the current enable mask.
- R5: A read at offset 0x24 returns the raw status ANDed bitwise with the enable mask.
- R6: A write to offset 0x24 clears each raw bit whose write-data bit is one, whatever the enable mask holds. Raw bits written as zero keep their value.
- R7: A write to offset 0x20 sets each raw bit whose write-data bit is one. Raw bits written as zero keep their value.
- R8: `irq_o` is high exactly when at least one bit of the masked status (R5) is one. It follows the registered state in the same cycle.
- R9: When an event and a software clear of the same raw bit fall on the same edge, the bit ends up set.
- R10: Read-data bits at positions NUM_SRC and above are zero. A write to an offset other than 0x20, 0x24, 0x28 or 0x2C changes no state, and a read there returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_SRC | Event pulses: bit 1 word-complete, bit 0 frame-complete |
| wr_en_i | input | 1 | Write strobe for the register port |
| addr_i | input | ADDR_W | Byte offset of the register accessed |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest situation to reach is an event pulse landing on the very edge where software acknowledges the same bit. Ordinary traffic almost never lines the two up. The bench forces the collision on purpose. It preloads raw status and mask through the port, then applies every register write together with every event pattern in one cycle. This sweeps all start states, all write data values and all four writable offsets, and the bench reads back all four views after each vector.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;

    localparam int unsigned OFS_RAW    = 32'h20;
    localparam int unsigned OFS_MASKED = 32'h24;
    localparam int unsigned OFS_EN_SET = 32'h28;
    localparam int unsigned OFS_EN_CLR = 32'h2C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RAW,
        SEL_MASKED,
        SEL_EN_SET,
        SEL_EN_CLR
    } reg_sel_e;

    typedef struct packed {
        logic raw;
        logic en;
    } cell_state_t;

endpackage

// File: rtl/flash_irq_wr_dec.sv
module flash_irq_wr_dec
    import flash_irq_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned NUM_SRC = 2
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_en_i,
    input  logic [NUM_SRC-1:0] wr_bits_i,
    output reg_sel_e           sel_o,
    output logic [NUM_SRC-1:0] raw_set_o,
    output logic [NUM_SRC-1:0] raw_clr_o,
    output logic [NUM_SRC-1:0] en_set_o,
    output logic [NUM_SRC-1:0] en_clr_o
);

    always_comb begin
        sel_o = SEL_NONE;
        if (addr_i == ADDR_W'(OFS_RAW))         sel_o = SEL_RAW;
        else if (addr_i == ADDR_W'(OFS_MASKED)) sel_o = SEL_MASKED;
        else if (addr_i == ADDR_W'(OFS_EN_SET)) sel_o = SEL_EN_SET;
        else if (addr_i == ADDR_W'(OFS_EN_CLR)) sel_o = SEL_EN_CLR;
    end

    always_comb begin
        raw_set_o = '0;
        raw_clr_o = '0;
        en_set_o  = '0;
        en_clr_o  = '0;
        if (wr_en_i) begin
            unique case (sel_o)
                SEL_RAW:    raw_set_o = wr_bits_i;
                SEL_MASKED: raw_clr_o = wr_bits_i;
                SEL_EN_SET: en_set_o  = wr_bits_i;
                SEL_EN_CLR: en_clr_o  = wr_bits_i;
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/flash_irq_bit_cell.sv
module flash_irq_bit_cell
    import flash_irq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic evt_i,
    input  logic raw_set_i,
    input  logic raw_clr_i,
    input  logic en_set_i,
    input  logic en_clr_i,
    output logic raw_o,
    output logic en_o
);

    cell_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (raw_clr_i) st_d.raw = 1'b0;
        if (raw_set_i) st_d.raw = 1'b1;
        // hardware event is applied last so it beats an acknowledge
        if (evt_i)     st_d.raw = 1'b1;
        if (en_clr_i)  st_d.en  = 1'b0;
        if (en_set_i)  st_d.en  = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign raw_o = st_q.raw;
    assign en_o  = st_q.en;

endmodule

// File: rtl/flash_irq_rd_mux.sv
module flash_irq_rd_mux
    import flash_irq_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_SRC = 2
) (
    input  reg_sel_e           sel_i,
    input  logic [NUM_SRC-1:0] raw_i,
    input  logic [NUM_SRC-1:0] en_i,
    output logic [NUM_SRC-1:0] masked_o,
    output logic [DATA_W-1:0]  rd_data_o
);

    assign masked_o = raw_i & en_i;

    always_comb begin
        rd_data_o = '0;
        unique case (sel_i)
            SEL_RAW:    rd_data_o = DATA_W'(raw_i);
            SEL_MASKED: rd_data_o = DATA_W'(masked_o);
            SEL_EN_SET,
            SEL_EN_CLR: rd_data_o = DATA_W'(en_i);
            default:    rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/flash_irq_ctrl.sv
module flash_irq_ctrl
    import flash_irq_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_SRC = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic               irq_o
);

    localparam int unsigned HI_W = DATA_W - NUM_SRC;

    reg_sel_e           sel;
    logic [NUM_SRC-1:0] raw_set, raw_clr, en_set, en_clr;
    logic [NUM_SRC-1:0] raw_vec, en_vec, masked_vec;
    logic [HI_W-1:0]    unused_wdata_hi;

    assign unused_wdata_hi = wr_data_i[DATA_W-1:NUM_SRC];

    flash_irq_wr_dec #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) dec_i (
        .addr_i    (addr_i),
        .wr_en_i   (wr_en_i),
        .wr_bits_i (wr_data_i[NUM_SRC-1:0]),
        .sel_o     (sel),
        .raw_set_o (raw_set),
        .raw_clr_o (raw_clr),
        .en_set_o  (en_set),
        .en_clr_o  (en_clr)
    );

    for (genvar b = 0; b < NUM_SRC; b++) begin : g_cell
        flash_irq_bit_cell cell_i (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .evt_i     (evt_i[b]),
            .raw_set_i (raw_set[b]),
            .raw_clr_i (raw_clr[b]),
            .en_set_i  (en_set[b]),
            .en_clr_i  (en_clr[b]),
            .raw_o     (raw_vec[b]),
            .en_o      (en_vec[b])
        );
    end

    flash_irq_rd_mux #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) mux_i (
        .sel_i     (sel),
        .raw_i     (raw_vec),
        .en_i      (en_vec),
        .masked_o  (masked_vec),
        .rd_data_o (rd_data_o)
    );

    assign irq_o = |masked_vec;

endmodule

// File: rtl/flash_irq_ctrl_chk.sv
module flash_irq_ctrl_chk #(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned NUM_SRC = 2
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_SRC-1:0] evt_i,
    input logic               wr_en_i,
    input logic [ADDR_W-1:0]  addr_i,
    input logic [NUM_SRC-1:0] wbits,
    input logic [NUM_SRC-1:0] raw_vec,
    input logic [NUM_SRC-1:0] en_vec,
    input logic               irq_o
);

    logic w_raw, w_msk, w_ens, w_enc;
    assign w_raw = wr_en_i && (addr_i == ADDR_W'(32'h20));
    assign w_msk = wr_en_i && (addr_i == ADDR_W'(32'h24));
    assign w_ens = wr_en_i && (addr_i == ADDR_W'(32'h28));
    assign w_enc = wr_en_i && (addr_i == ADDR_W'(32'h2C));

    AST_EVT_SETS_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|evt_i) |=> ((raw_vec & $past(evt_i)) == $past(evt_i)));  // R2

    AST_EN_SET_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        w_ens |=> ((en_vec & $past(wbits)) == $past(wbits)));  // R3

    AST_EN_CLR_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        w_enc |=> ((en_vec & $past(wbits)) == '0));  // R4

    AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(w_ens || w_enc) |=> $stable(en_vec));  // R10

    AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (w_msk && evt_i == '0) |=> ((raw_vec & $past(wbits)) == '0));  // R6

    AST_RAW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!w_raw && !w_msk && evt_i == '0) |=> $stable(raw_vec));  // R2

    AST_IRQ_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == ((raw_vec & en_vec) != '0));  // R8

endmodule

bind flash_irq_ctrl flash_irq_ctrl_chk #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt_i),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wbits   (wr_data_i[NUM_SRC-1:0]),
    .raw_vec (raw_vec),
    .en_vec  (en_vec),
    .irq_o   (irq_o)
);

// File: tb/flash_irq_ctrl_tb_top.sv
module flash_irq_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int NUM_SRC = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_SRC-1:0] evt = '0;
    logic               wr_en = 1'b0;
    logic [ADDR_W-1:0]  addr = '0;
    logic [DATA_W-1:0]  wdata = '0;
    logic [DATA_W-1:0]  rdata;
    logic               irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_irq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .evt_i     (evt),
        .wr_en_i   (wr_en),
        .addr_i    (addr),
        .wr_data_i (wdata),
        .rd_data_o (rdata),
        .irq_o     (irq)
    );

    task automatic check(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp,
                         input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock: drive at falling edge, release shortly after rising edge
    task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d,
                       input logic [1:0] e);
        @(negedge clk);
        wr_en = we; addr = a; wdata = d; evt = e;
        @(posedge clk);
        #1;
        wr_en = 1'b0; evt = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        for (int a = 'h20; a <= 'h2C; a += 4) begin
            rd(8'(a), v);
            check(v, 32'h0, "R1");
        end
        check({31'b0, irq}, 32'h0, "R1");
        @(negedge clk); rst_n = 1'b1;

        // R2 word-complete pulse, masked; then enable raises irq (R8)
        cyc(1'b0, 8'h00, 32'h0, 2'b10);
        rd(8'h20, v); check(v, 32'h2, "R2");
        check({31'b0, irq}, 32'h0, "R8");
        cyc(1'b0, 8'h00, 32'h0, 2'b00);
        rd(8'h20, v); check(v, 32'h2, "R2");
        cyc(1'b1, 8'h28, 32'h2, 2'b00);
        check({31'b0, irq}, 32'h1, "R8");

        // R10 unmapped write has no effect and reads zero
        cyc(1'b1, 8'h30, 32'hFFFF_FFFF, 2'b00);
        rd(8'h30, v); check(v, 32'h0, "R10");
        rd(8'h20, v); check(v, 32'h2, "R10");
        rd(8'h28, v); check(v, 32'h2, "R10");
        cyc(1'b1, 8'h24, 32'h0, 2'b00);
        rd(8'h20, v); check(v, 32'h2, "R6");
        cyc(1'b1, 8'h24, 32'h2, 2'b00);
        check({31'b0, irq}, 32'h0, "R6");

        // exhaustive sweep: start raw, start mask, register, data, events
        for (int r0 = 0; r0 < 4; r0++)
        for (int e0 = 0; e0 < 4; e0++)
        for (int op = 0; op < 4; op++)
        for (int wd = 0; wd < 4; wd++)
        for (int ev = 0; ev < 4; ev++) begin
            logic [1:0] er, ee;
            string tag;
            cyc(1'b1, 8'h2C, 32'h3, 2'b00);
            cyc(1'b1, 8'h24, 32'h3, 2'b00);
            cyc(1'b1, 8'h20, 32'(r0), 2'b00);
            cyc(1'b1, 8'h28, 32'(e0), 2'b00);
            cyc(1'b1, 8'(32'h20 + 4*op), {30'h3FFF_FFFF, 2'(wd)}, 2'(ev));
            er = 2'(r0); ee = 2'(e0);
            case (op)
                0: begin er = er | 2'(wd);  tag = "R7"; end
                1: begin er = er & ~2'(wd); tag = (ev != 0) ? "R9" : "R6"; end
                2: begin ee = ee | 2'(wd);  tag = "R3"; end
                default: begin ee = ee & ~2'(wd); tag = "R4"; end
            endcase
            er = er | 2'(ev);
            rd(8'h20, v); check(v, {30'b0, er}, (ev != 0) ? "R2" : tag);
            rd(8'h24, v); check(v, {30'b0, er & ee}, "R5");
            rd(8'h28, v); check(v, {30'b0, ee}, tag);
            rd(8'h2C, v); check(v, {30'b0, ee}, "R4");
            check({31'b0, irq}, {31'b0, |(er & ee)}, "R8");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule